// File: doc/BRIEF.md
# SDRAM Data Mask and Auto-Precharge Timer

This block follows each SDRAM column access clock by clock. It produces three controls for the data path and the bank logic: an output enable for read data, a per-beat write enable, and a one-cycle pulse that starts an internal precharge when the access asked for one. The controller issues a read or write strobe together with the auto-precharge address flag (address bit 10), a burst length select and the programmed CAS latency. The data mask input is then applied beat by beat.

Reads and writes use the mask with different latencies. On a read, the mask takes the output driver off two clocks after it is sampled. On a write, it blocks the beat on the bus in the same clock. For auto-precharge the pulse is placed against the last data beat, so its distance from that beat grows with the CAS latency on reads. On writes it falls on the clock after the last beat.

Top module: `sdr_mask_ap_timer`

## Requirements
- R1: With a read sampled at edge E, `dq_oe` is high after edges E+CL through E+CL+BL-1 and low otherwise (CL is the CAS latency, BL the burst length).
- R2: `dqm` high when sampled at edge M forces `dq_oe` low after edge M+2 and has no other effect on reads.
- R3: With a write sampled at edge E, `wr_beat_en` is high during the clock periods whose inputs are sampled at edges E through E+BL-1, and low otherwise.
- R4: `dqm` high in a clock period forces `wr_beat_en` low in that same period, with zero latency.
- R5: A read with `ap_flag` high gives a `pre_start` pulse CL-1 clocks before the last read data cycle, which is the cycle after edge E+BL.
- R6: A write with `ap_flag` high gives a `pre_start` pulse after the first edge following the edge that samples the last write beat, which is the cycle after edge E+BL.
- R7: `pre_start` lasts one clock per access. No pulse comes from an access whose `ap_flag` was low.
- R8: `bl_sel` values 0, 1, 2, 3 select burst lengths 1, 2, 4, 8. `cas_lat` carries the CAS latency in binary, and only 2, 3 and 4 are legal with a read.
- R9: A new command restarts tracking. A write ends a read's output window from its own edge on, a read ends the remaining write beats, and a pending precharge of the older access is dropped.
- R10: During and right after reset, all three outputs are low.
- R11: When both strobes are high, the write is taken and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| ap_flag | input | 1 | Address bit 10 sampled with the command; requests auto-precharge |
| dqm | input | 1 | Data mask |
| bl_sel | input | 2 | Burst length select (1, 2, 4, 8) |
| cas_lat | input | 3 | CAS latency in binary (2 to 4) |
| dq_oe | output | 1 | Read data output enable |
| wr_beat_en | output | 1 | Write enable for the current beat |
| pre_start | output | 1 | One-cycle internal precharge start |

## Verification
A read counter that is off by one moves the whole `dq_oe` window by a clock. The first and last beats of the next read show this, at CL cycles after its command. A fault in the two-stage mask pipe masks the wrong beat, and this shows at the mask edge plus one or three instead of plus two. A precharge counter loaded with the wrong offset, or not cleared by a newer command, gives a `pre_start` pulse in the wrong cycle or an extra pulse. This shows within BL clocks of the command that set it up. Write-side faults show in the same clock, because the write enable follows the strobe and mask directly.

// File: rtl/sdr_timer_pkg.sv
package sdr_timer_pkg;

    // Burst length select code to number of beats: 0,1,2,3 -> 1,2,4,8.
    function automatic int unsigned burst_beats(input logic [1:0] sel);
        return 32'd1 << sel;
    endfunction

    // Read: last data edge is cmd+CL+BL-1; precharge leads it by CL-1 edges.
    function automatic int unsigned rd_pre_offset(input int unsigned cl,
                                                  input int unsigned bl);
        return (cl + bl - 1) - (cl - 1);
    endfunction

    // Write: last beat sampled at cmd+BL-1; precharge one edge later.
    function automatic int unsigned wr_pre_offset(input int unsigned bl);
        return (bl - 1) + 1;
    endfunction

endpackage

// File: rtl/sdr_mask_delay.sv
module sdr_mask_delay #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (LAT == 0) begin : g_direct
            assign dout = din;
        end else begin : g_pipe
            logic [LAT-1:0] sh_d, sh_q;

            always_comb begin
                sh_d    = sh_q << 1;
                sh_d[0] = din;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end

            assign dout = sh_q[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/sdr_rd_window.sv
module sdr_rd_window #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          kill,
    input  logic [CW-1:0] cl,
    input  logic [CW-1:0] bl,
    input  logic          mask_late,
    output logic          oe
);
    typedef struct packed {
        logic          act;
        logic [CW-1:0] n;
        logic [CW-1:0] cl;
        logic [CW-1:0] bl;
        logic          oe;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [CW-1:0] n_next;

    always_comb begin
        st_d   = st_q;
        n_next = st_q.n + 1'b1;
        if (start) begin
            st_d.act = 1'b1;
            st_d.n   = '0;
            st_d.cl  = cl;
            st_d.bl  = bl;
            st_d.oe  = 1'b0;
        end else if (kill) begin
            st_d.act = 1'b0;
            st_d.oe  = 1'b0;
        end else if (st_q.act) begin
            st_d.n  = n_next;
            st_d.oe = (n_next >= st_q.cl) && (n_next < st_q.cl + st_q.bl) && !mask_late;
            if (n_next >= st_q.cl + st_q.bl - 1'b1) st_d.act = 1'b0;
        end else begin
            st_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe = st_q.oe;

    // R1: data never drives on the edge right after a command (CL >= 2)
    p_oe_quiet_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !oe);

    // R9: a write ends the read window at once
    p_kill_stops_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !start) |=> !oe);
endmodule

// File: rtl/sdr_wr_beats.sv
module sdr_wr_beats #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          kill,
    input  logic [CW-1:0] bl,
    input  logic          dqm,
    output logic          beat_en
);
    typedef struct packed {
        logic [CW-1:0] left;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)                  st_d.left = bl - 1'b1;
        else if (kill)              st_d.left = '0;
        else if (st_q.left != '0)   st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_en = (start || ((st_q.left != '0) && !kill)) && !dqm;

    // R9: after a read takes over, only a fresh write can enable a beat
    p_kill_ends_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !start) |=> (!beat_en || start));
endmodule

// File: rtl/sdr_ap_timer.sv
module sdr_ap_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ap,
    input  logic [CW-1:0] offset,
    output logic          pulse
);
    typedef struct packed {
        logic          arm;
        logic [CW-1:0] cnt;
        logic          pulse;
    } ap_state_t;

    ap_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (start) begin
            st_d.arm = ap;
            st_d.cnt = offset - 1'b1;
        end else if (st_q.arm) begin
            if (st_q.cnt == '0) begin
                st_d.pulse = 1'b1;
                st_d.arm   = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R7: an access without the precharge flag never pulses next cycle
    p_no_pulse_without_ap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ap) |=> !pulse);
endmodule

// File: rtl/sdr_mask_ap_timer.sv
module sdr_mask_ap_timer #(
    parameter int MAX_BL      = 8,
    parameter int MAX_CL      = 4,
    parameter int RD_MASK_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_cmd,
    input  logic       wr_cmd,
    input  logic       ap_flag,
    input  logic       dqm,
    input  logic [1:0] bl_sel,
    input  logic [2:0] cas_lat,
    output logic       dq_oe,
    output logic       wr_beat_en,
    output logic       pre_start
);
    import sdr_timer_pkg::*;

    localparam int CW = $clog2(MAX_CL + MAX_BL + 1);

    logic          rd_go, wr_go, any_go, dqm_late;
    logic [CW-1:0] bl_val, cl_val, pre_off;

    // R11: write wins when both strobes are high
    assign wr_go  = wr_cmd;
    assign rd_go  = rd_cmd && !wr_cmd;
    assign any_go = rd_go || wr_go;

    assign bl_val  = CW'(burst_beats(bl_sel));
    assign cl_val  = CW'(cas_lat);
    assign pre_off = rd_go ? CW'(rd_pre_offset(int'(cas_lat), int'(bl_val)))
                           : CW'(wr_pre_offset(int'(bl_val)));

    sdr_mask_delay #(.LAT(RD_MASK_LAT)) u_mask_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dqm),
        .dout (dqm_late)
    );

    sdr_rd_window #(.CW(CW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rd_go),
        .kill     (wr_go),
        .cl       (cl_val),
        .bl       (bl_val),
        .mask_late(dqm_late),
        .oe       (dq_oe)
    );

    sdr_wr_beats #(.CW(CW)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_go),
        .kill   (rd_go),
        .bl     (bl_val),
        .dqm    (dqm),
        .beat_en(wr_beat_en)
    );

    sdr_ap_timer #(.CW(CW)) u_ap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (any_go),
        .ap    (ap_flag),
        .offset(pre_off),
        .pulse (pre_start)
    );

    // Assertion support: count edges since reset so $past stays inside them.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R2: read mask removes output two edges after it is sampled
    p_rd_mask_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && $past(dqm, 3)) |-> !dq_oe);

    // R8: only CAS latencies 2..4 accompany a read
    p_cl_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |-> (cas_lat >= 3'd2 && cas_lat <= 3'd4));
endmodule

// File: tb/sdr_mask_ap_timer_tb.sv
`timescale 1ns/100ps
module sdr_mask_ap_timer_tb;
    localparam int NE      = 256;
    localparam int END_E   = 220;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_cmd = 1'b0, wr_cmd = 1'b0, ap_flag = 1'b0, dqm = 1'b0;
    logic [1:0] bl_sel = 2'd0;
    logic [2:0] cas_lat = 3'd2;
    logic       dq_oe, wr_beat_en, pre_start;

    int total = 0;
    int bad   = 0;
    int edge_n = 0;
    bit mon_en = 1'b0;

    // stimulus plan per sampling edge
    bit plan_rd[NE], plan_wr[NE], plan_ap[NE], plan_dqm[NE];
    int plan_bls[NE], plan_cl[NE];
    // scoreboard: expected output per monitor edge
    bit    exp_oe[NE], exp_we[NE], exp_pr[NE];
    string tg_oe[NE], tg_we[NE], tg_pr[NE];

    sdr_mask_ap_timer u_dut (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .ap_flag(ap_flag), .dqm(dqm), .bl_sel(bl_sel), .cas_lat(cas_lat),
        .dq_oe(dq_oe), .wr_beat_en(wr_beat_en), .pre_start(pre_start)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic check(input bit act, input bit expv, input string req, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s at edge %0d: got %0b expected %0b", req, what, edge_n, act, expv);
        end
    endtask

    // Driver: schedules one access at edge e0 and pushes its expectations.
    task automatic sched(input int e0, input bit wr, input bit ap, input int bls,
                         input int cl, input bit [7:0] mask);
        int bl;
        bl = 1 << bls;
        for (int k = e0; k < NE; k++) begin
            if (exp_oe[k]) tg_oe[k] = "R9";
            if (exp_pr[k]) tg_pr[k] = "R9";
            exp_oe[k] = 1'b0;
            exp_pr[k] = 1'b0;
        end
        for (int k = e0 - 1; k < NE; k++) begin
            if (exp_we[k]) tg_we[k] = "R9";
            exp_we[k] = 1'b0;
        end
        plan_rd[e0]  = !wr;
        plan_wr[e0]  = wr;
        plan_ap[e0]  = ap;
        plan_bls[e0] = bls;
        plan_cl[e0]  = cl;
        if (!wr) begin
            for (int i = 0; i < bl; i++) begin
                if (mask[i]) begin
                    plan_dqm[e0 + cl + i - 2] = 1'b1;
                    tg_oe[e0 + cl + i] = "R2";
                end else begin
                    exp_oe[e0 + cl + i] = 1'b1;
                    tg_oe[e0 + cl + i] = "R1,R8";
                end
            end
            // last data edge e0+cl+bl-1, pulse cl-1 earlier
            exp_pr[e0 + cl + bl - 1 - (cl - 1)] = ap;
            tg_pr[e0 + bl] = ap ? "R5" : "R7";
        end else begin
            for (int i = 0; i < bl; i++) begin
                if (mask[i]) begin
                    plan_dqm[e0 + i] = 1'b1;
                    tg_we[e0 + i - 1] = "R4";
                end else begin
                    exp_we[e0 + i - 1] = 1'b1;
                    tg_we[e0 + i - 1] = "R3,R8";
                end
            end
            exp_pr[e0 + bl] = ap;
            tg_pr[e0 + bl] = ap ? "R6" : "R7";
        end
    endtask

    // Driver process: inputs for edge k+1 set at the falling edge
    always @(negedge clk) begin
        int k;
        k = edge_n + 1;
        if (k < NE) begin
            rd_cmd  = plan_rd[k];
            wr_cmd  = plan_wr[k];
            ap_flag = plan_ap[k];
            dqm     = plan_dqm[k];
            bl_sel  = 2'(plan_bls[k]);
            cas_lat = (plan_rd[k] || plan_wr[k]) ? 3'(plan_cl[k]) : 3'd3;
        end
    end

    // Monitor: compare all outputs against the scoreboard each cycle
    always @(negedge clk) begin
        #1;
        if (mon_en && edge_n < END_E) begin
            check(dq_oe,      exp_oe[edge_n], tg_oe[edge_n], "dq_oe");
            check(wr_beat_en, exp_we[edge_n], tg_we[edge_n], "wr_beat_en");
            check(pre_start,  exp_pr[edge_n], tg_pr[edge_n], "pre_start");
        end
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired at edge %0d", edge_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NE; k++) begin
            tg_oe[k] = "R1";
            tg_we[k] = "R3";
            tg_pr[k] = "R7";
        end
        // R1 R5: CL2 BL4 with precharge
        sched(10, 1'b0, 1'b1, 2, 2, 8'h00);
        // R2 R5: CL3 BL8 masked beats 1 and 6
        sched(30, 1'b0, 1'b1, 3, 3, 8'h42);
        // R7: CL4 BL2 without precharge
        sched(50, 1'b0, 1'b0, 1, 4, 8'h00);
        // R5: CL4 BL1, pulse three edges before the only beat
        sched(60, 1'b0, 1'b1, 0, 4, 8'h00);
        // R4 R6: write BL4, beat 2 masked
        sched(80, 1'b1, 1'b1, 2, 3, 8'h04);
        // R4 R7: write BL8, first and last beats masked
        sched(100, 1'b1, 1'b0, 3, 3, 8'h81);
        // R6: write BL1
        sched(120, 1'b1, 1'b1, 0, 3, 8'h00);
        // R9: read interrupted by write, pending precharge dropped
        sched(140, 1'b0, 1'b1, 3, 3, 8'h00);
        sched(145, 1'b1, 1'b0, 1, 3, 8'h00);
        // R9: write interrupted by read with precharge
        sched(160, 1'b1, 1'b1, 3, 3, 8'h00);
        sched(163, 1'b0, 1'b1, 1, 2, 8'h00);
        // R11: both strobes at 190 -> write BL2 taken, read ignored
        sched(190, 1'b1, 1'b1, 1, 2, 8'h00);
        plan_rd[190] = 1'b1;
        tg_we[189] = "R11"; tg_we[190] = "R11"; tg_oe[192] = "R11"; tg_pr[192] = "R11";

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: outputs low right after reset
        check(dq_oe,      1'b0, "R10", "dq_oe after reset");
        check(pre_start,  1'b0, "R10", "pre_start after reset");
        check(wr_beat_en, 1'b0, "R10", "wr_beat_en after reset");
        mon_en = 1'b1;
        while (edge_n < END_E + 2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule